// File: doc/BRIEF.md
# Selectable-Source Countdown Timer

This block is an 8-bit periodic countdown timer. It advances on one of four externally prescaled tick strobes, picked by a two-bit source code. While it runs, every selected tick lowers the count by one. When the count would reach zero, the block sets a timer flag and reloads the count from a programmed period value on that same tick.

The flag can drive an interrupt pin in one of two ways. In level mode the pin follows the flag and stays asserted until software clears the flag. In pulse mode the pin asserts for one period of the selected tick, then releases even if the flag stays set.

Software reaches the block through plain control pins. These carry the enable, the source code, the interrupt enable and the mode bit, plus a write strobe for the period value and a write strobe for the flag. Every pin is a control or status pin. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `countdown_tmr`

## Requirements
- R1: While reset is asserted, and after it is released, `tmr_flag_o` and `tmr_irq_o` are 0, and the stored period value is 0.
- R2: `src_sel_i` picks which bit of `tick_vec_i` advances the counter: code 0 uses bit 0 (4096 Hz), code 1 uses bit 1 (64 Hz), code 2 uses bit 2 (1 Hz) and code 3 uses bit 3 (1/60 Hz). Strobes on the other bits have no effect.
- R3: While `run_en_i` is 0, the count is held at the stored period value and the flag is never set.
- R4: While enabled with a stored value N ≥ 1, the flag is set after the Nth selected tick, and every later expiry comes N ticks after the one before. The flag becomes visible in the cycle after the tick. A stored value of 0 behaves like 1.
- R5: A cycle with `flag_wr_i`=1 and `flag_wdata_i`=0 clears the flag. A write with `flag_wdata_i`=1 leaves the flag unchanged. If an expiry and a clear fall in the same cycle, the expiry wins.
- R6: With `irq_en_i`=1 and `pulse_mode_i`=0, `tmr_irq_o` equals the flag.
- R7: With `irq_en_i`=1 and `pulse_mode_i`=1, `tmr_irq_o` rises in the cycle after an expiry. It falls in the cycle after the next selected tick that is not itself an expiry, whatever the state of the flag.
- R8: With `irq_en_i`=0, `tmr_irq_o` is 0, while the flag keeps being set on expiry.
- R9: A `period_wr_i` strobe stores `period_i` and restarts the count from that value, even while the timer runs. A tick in the same cycle as the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick_vec_i | input | 4 | One-cycle tick strobes: bit 0 = 4096 Hz, bit 1 = 64 Hz, bit 2 = 1 Hz, bit 3 = 1/60 Hz |
| src_sel_i | input | 2 | Tick source code |
| run_en_i | input | 1 | Countdown enable |
| period_wr_i | input | 1 | Write strobe for the period value |
| period_i | input | 8 | Period value to write |
| flag_wr_i | input | 1 | Write strobe for the flag bit |
| flag_wdata_i | input | 1 | Value written to the flag (0 clears, 1 keeps) |
| irq_en_i | input | 1 | Timer interrupt enable |
| pulse_mode_i | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| tmr_flag_o | output | 1 | Timer flag |
| tmr_irq_o | output | 1 | Timer interrupt pin, active high |

## Verification
The embedded assertions check these rules on every cycle:
- at most one tick source is ever routed to the counter;
- a disabled timer holds its stored period;
- a period write restarts the count;
- an expiry always sets the flag, and a clear with no expiry in the same cycle always removes it;
- a pulse releases on the next non-expiring tick;
- a disabled interrupt keeps the pin low.

Other behaviour can only be shown by the bench's scenarios, which compare the design against a cycle-by-cycle behavioural model. This covers the exact tick count between expiries for each source code and for a period of 0, the length of the pulse window measured against real tick spacing, and the level/pulse choice seen at the pin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_NSRC  = 4;
  localparam int unsigned TMR_SEL_W = $clog2(TMR_NSRC);
  localparam int unsigned TMR_CNT_W = 8;

  typedef enum logic [TMR_SEL_W-1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_MIN  = 2'd3
  } tmr_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int unsigned NSRC  = 4,
  parameter int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_vec_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = tick_vec_i[g] & (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;

  // R2
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] val_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last     = (cnt_q <= ONE);
  assign expire_o = en_i & tick_i & ~wr_i & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (wr_i) begin
      val_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
    end else if (!en_i) begin
      cnt_q <= val_q;
    end else if (tick_i) begin
      cnt_q <= last ? val_q : cnt_q - ONE;
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i)) && (val_q == $past(wdata_i)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !wr_i) |=> (cnt_q == $past(val_q)));
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic tick_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  input  logic irq_en_i,
  input  logic pulse_mode_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire_i) begin
      flag_q <= 1'b1;
    end else if (clr_wr_i && !clr_data_i) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
    end else if (expire_i) begin
      pulse_q <= 1'b1;
    end else if (tick_i) begin
      pulse_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_en_i & (pulse_mode_i ? pulse_q : flag_q);

  // R4
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_i && !clr_data_i && !expire_i) |=> !flag_q);

  // R7
  pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && tick_i && !expire_i) |=> !pulse_q);
endmodule

// File: rtl/countdown_tmr.sv
module countdown_tmr #(
  parameter int unsigned NSRC  = tmr_pkg::TMR_NSRC,
  parameter int unsigned CNT_W = tmr_pkg::TMR_CNT_W,
  localparam int unsigned SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  tick_vec_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             run_en_i,
  input  logic             period_wr_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             flag_wr_i,
  input  logic             flag_wdata_i,
  input  logic             irq_en_i,
  input  logic             pulse_mode_i,
  output logic             tmr_flag_o,
  output logic             tmr_irq_o
);
  logic sel_tick;
  logic expire;

  tmr_tick_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_vec_i (tick_vec_i),
    .sel_i      (src_sel_i),
    .tick_o     (sel_tick)
  );

  tmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (run_en_i),
    .tick_i   (sel_tick),
    .wr_i     (period_wr_i),
    .wdata_i  (period_i),
    .expire_o (expire)
  );

  tmr_irq_out u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .expire_i     (expire),
    .tick_i       (sel_tick),
    .clr_wr_i     (flag_wr_i),
    .clr_data_i   (flag_wdata_i),
    .irq_en_i     (irq_en_i),
    .pulse_mode_i (pulse_mode_i),
    .flag_o       (tmr_flag_o),
    .irq_o        (tmr_irq_o)
  );

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !tmr_irq_o);

  // R3
  idle_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_i && !tmr_flag_o) |=> !tmr_flag_o);
endmodule

// File: tb/countdown_tmr_tb_top.sv
module countdown_tmr_tb_top;
  import tmr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick_vec = '0;
  logic [1:0] src_sel = '0;
  logic       run_en = 1'b0;
  logic       period_wr = 1'b0;
  logic [7:0] period = '0;
  logic       flag_wr = 1'b0;
  logic       flag_wdata = 1'b0;
  logic       irq_en = 1'b0;
  logic       pulse_mode = 1'b0;
  logic       tmr_flag;
  logic       tmr_irq;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model state
  int m_val = 0, m_cnt = 0;
  bit m_flag = 0, m_pulse = 0;

  always #2.5 clk = ~clk;

  countdown_tmr dut_i (
    .clk(clk), .rst_n(rst_n), .tick_vec_i(tick_vec), .src_sel_i(src_sel),
    .run_en_i(run_en), .period_wr_i(period_wr), .period_i(period),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata), .irq_en_i(irq_en),
    .pulse_mode_i(pulse_mode), .tmr_flag_o(tmr_flag), .tmr_irq_o(tmr_irq)
  );

  // model: advance on each clock edge using the inputs held since posedge+1
  always @(posedge clk) begin
    if (!rst_n) begin
      m_val = 0; m_cnt = 0; m_flag = 0; m_pulse = 0;
    end else begin
      bit tk, exp_now;
      tk = tick_vec[src_sel];
      exp_now = run_en && tk && !period_wr && (m_cnt <= 1);
      if (period_wr) begin
        m_val = period; m_cnt = period;
      end else if (!run_en) m_cnt = m_val;
      else if (tk) m_cnt = (m_cnt <= 1) ? m_val : m_cnt - 1;
      if (exp_now) m_flag = 1;
      else if (flag_wr && !flag_wdata) m_flag = 0;
      if (exp_now) m_pulse = 1;
      else if (tk) m_pulse = 0;
    end
  end

  task automatic check(string what, bit act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", cur_req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("flag", tmr_flag, m_flag);
      check("irq", tmr_irq, irq_en && (pulse_mode ? m_pulse : m_flag));
    end
  end

  // drive one cycle: ticks follow fixed, co-prime spacing per source
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cyc++;
      tick_vec[0] = (cyc % 3) == 0;
      tick_vec[1] = (cyc % 7) == 0;
      tick_vec[2] = (cyc % 13) == 0;
      tick_vec[3] = (cyc % 29) == 0;
      period_wr = 0; flag_wr = 0;
    end
  endtask

  task automatic write_period(logic [7:0] v);
    @(posedge clk); #1;
    period = v; period_wr = 1;
    step(1);
  endtask

  task automatic write_flag(bit v);
    @(posedge clk); #1;
    flag_wdata = v; flag_wr = 1;
    step(1);
  endtask

  initial begin
    #(5 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1";
    check("reset flag", tmr_flag, 0);
    check("reset irq", tmr_irq, 0);
    rst_n = 1;
    step(20);

    // R2: each source code with period 3, level interrupt
    cur_req = "R2";
    irq_en = 1; pulse_mode = 0;
    write_period(8'd3);
    run_en = 1;
    src_sel = SRC_FAST; step(120); write_flag(0);
    src_sel = SRC_MID;  step(200); write_flag(0);
    src_sel = SRC_SEC;  step(300); write_flag(0);
    src_sel = SRC_MIN;  step(400); write_flag(0);

    // R3: disabled timer never flags
    cur_req = "R3";
    run_en = 0; src_sel = SRC_FAST;
    write_flag(0);
    step(150);

    // R4: period 5 and period 0
    cur_req = "R4";
    write_period(8'd5); run_en = 1;
    step(60); write_flag(0); step(40);
    write_period(8'd0); step(30); write_flag(0);

    // R5: writing 1 keeps, writing 0 clears
    cur_req = "R5";
    write_period(8'd2); step(20);
    write_flag(1); step(2); write_flag(0); step(5);
    for (int k = 0; k < 20; k++) begin write_flag(0); step(k % 4); end

    // R6: level interrupt follows the flag
    cur_req = "R6";
    pulse_mode = 0; write_period(8'd4); step(80); write_flag(0); step(30);

    // R7: pulsed interrupt on a slower source, flag left set
    cur_req = "R7";
    pulse_mode = 1; src_sel = SRC_MID; write_period(8'd3); step(250);
    write_flag(0); step(100);

    // R8: interrupt masked
    cur_req = "R8";
    irq_en = 0; step(150); pulse_mode = 0; step(100);

    // R9: period rewrites while running
    cur_req = "R9";
    irq_en = 1; src_sel = SRC_FAST;
    for (int k = 0; k < 12; k++) begin
      write_period(8'(k % 5 + 1)); step(k + 2); write_flag(0);
    end
    step(40);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule